// File: doc/BRIEF.md
# Serial Audio Transmit Frame and Clock Shutdown Controller

This block is the master-side timing core of a single-channel serial audio transmitter. It produces the frame sync, a bit-clock enable that gates the outgoing bit clock, and the serial data bit, which comes from its own parallel-load shifter. One system clock cycle is one bit period. The frame length can be set from 8 to 64 bits. A data word and a ready indication are sampled at each frame start. The frame sync marks the first bit of every frame.

Dropping the transmit enable never cuts a frame short. The block finishes the frame in progress and then keeps producing clock-only frames until a clock-stop request is pending. The stop request is a separate, sticky request. It may arrive in any frame before or after the enable drops. Once it is pending and no data frame follows, the bit clock and frame sync stop at the next frame boundary, and a sticky completion flag is raised. Software clears the flag by writing one to it. If the enable is dropped inside the final four bits of a frame, the next frame is still sent, but its data is flagged as invalid.

Top module: `i2s_tx_shutdown_ctrl`

## Requirements
- R1: After reset, `bclk_en`, `fsync`, `sdata`, `data_vld` and `done_flag` are all low.
- R2: While stopped, a clock edge that sees `tx_en` high starts a frame in the next cycle. A running frame lasts exactly the `frame_len` cycles latched at its start edge. `fsync` is high only in the first bit of each frame and `bclk_en` is high throughout.
- R3: In bit k of a data frame (k = 0 first), `sdata` equals bit 63-k of the `tx_word` sampled at the frame's start edge. The word is left-justified and sent MSB first. In clock-only frames `sdata` is 0, and it is 0 whenever stopped.
- R4: `data_vld` is constant across a frame. It is high only for a data frame whose start edge saw `word_rdy` high and that is not a late-disable frame.
- R5: Lowering `tx_en` during a frame does not shorten that frame. A frame is followed by another data frame when `tx_en` was high at the edge ending bit `len-5`.
- R6: If that edge saw `tx_en` high, but `tx_en` is low on any of the four edges ending bits `len-4` to `len-1`, exactly one extra data frame follows with `data_vld` low.
- R7: If no data frame follows and no stop is pending, clock-only frames continue with `fsync` and `bclk_en` active, and `data_vld` stays low.
- R8: A `clk_stop_req` pulse while running is held as pending. At the first frame boundary not followed by a data frame, `bclk_en` and `fsync` drop in the next cycle.
- R9: A stop request raised while clock-only frames run ends the clocks at the end of the frame in progress.
- R10: `done_flag` rises in the same cycle the clocks stop. It stays high until a `done_clr` pulse. A new shutdown in the same cycle as the clear wins.
- R11: A rising edge of `tx_en` discards a pending stop request, and it wins over a request in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, one bit period per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmit enable |
| clk_stop_req | input | 1 | Request to stop clock and frame sync (pulse) |
| frame_len | input | 7 | Frame length in bits, 8 to 64 |
| tx_word | input | 64 | Left-justified data word for the next frame |
| word_rdy | input | 1 | `tx_word` holds fresh data |
| done_clr | input | 1 | Write-one-to-clear for `done_flag` |
| bclk_en | output | 1 | Bit-clock gate enable |
| fsync | output | 1 | Frame sync, first bit of each frame |
| sdata | output | 1 | Serial data bit |
| data_vld | output | 1 | Current frame carries valid data |
| done_flag | output | 1 | Sticky shutdown-complete status |

## Verification
The assertions assume that `frame_len` is between 8 and 64 at every frame start edge. They also assume that `done_clr` and `clk_stop_req` are synchronous single-bit inputs. The length-bound check and the boundary-only shutdown check rely on these. The random stimulus always draws the length from 8 to 64. It changes the enable only rarely, so that disables fall mid-frame, inside the late window and during clock-only frames. Directed sequences place the enable drop on specific bit indices that are counted from the observed frame sync.

// File: rtl/i2s_fsd_pkg.sv
package i2s_fsd_pkg;
   // kind of frame the sequencer is producing
   typedef enum logic [1:0] {
      FK_STOP = 2'd0,
      FK_DATA = 2'd1,
      FK_FILL = 2'd2
   } frame_kind_t;

   function automatic int unsigned len_bits(input int unsigned max_len);
      return $clog2(max_len + 1);
   endfunction
endpackage

// File: rtl/fsd_frame_timer.sv
module fsd_frame_timer #(
   parameter int unsigned MAX_LEN  = 64,
   parameter int unsigned LATE_WIN = 4,
   parameter int unsigned LW       = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic          start,
   input  logic [LW-1:0] len_in,
   output logic          first_bit,
   output logic          last_bit,
   output logic          snap_edge,
   output logic          in_win
);
   localparam logic [LW-1:0] WIN_L  = LW'(LATE_WIN);
   localparam logic [LW-1:0] SNAP_L = LW'(LATE_WIN + 1);

   logic [LW-1:0] cnt;
   logic [LW-1:0] len_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         len_q <= LW'(MAX_LEN);
      end else if (start) begin
         cnt   <= '0;
         len_q <= len_in;
      end else if (run) begin
         cnt   <= cnt + 1'b1;
      end
   end

   assign first_bit = run && (cnt == '0);
   assign last_bit  = run && (cnt == len_q - 1'b1);
   assign snap_edge = run && (cnt == len_q - SNAP_L);
   assign in_win    = run && (cnt >= len_q - WIN_L);

   // R2
   cnt_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (cnt < len_q));
endmodule

// File: rtl/fsd_enable_watch.sv
module fsd_enable_watch (
   input  logic clk,
   input  logic rst_n,
   input  logic tx_en,
   input  logic snap_edge,
   input  logic in_win,
   output logic en_commit,
   output logic win_clean
);
   logic win_bad;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_commit <= 1'b0;
         win_bad   <= 1'b0;
      end else if (snap_edge) begin
         en_commit <= tx_en;
         win_bad   <= 1'b0;
      end else if (in_win && !tx_en) begin
         win_bad   <= 1'b1;
      end
   end

   // window is clean only if enable also holds on the boundary edge itself
   assign win_clean = !win_bad && tx_en;
endmodule

// File: rtl/fsd_stop_ctrl.sv
module fsd_stop_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic tx_en,
   input  logic stop_req,
   input  logic shutdown,
   input  logic done_clr,
   output logic pend_eff,
   output logic done_flag
);
   logic pend;
   logic en_q;
   logic en_rise;

   assign en_rise  = tx_en && !en_q;
   assign pend_eff = pend || (run && stop_req);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend      <= 1'b0;
         en_q      <= 1'b0;
         done_flag <= 1'b0;
      end else begin
         en_q <= tx_en;
         if (shutdown || en_rise) pend <= 1'b0;
         else                     pend <= pend_eff;
         if (shutdown)      done_flag <= 1'b1;
         else if (done_clr) done_flag <= 1'b0;
      end
   end

   // R10
   flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_flag) |-> $past(shutdown));
   // R11
   rise_drops_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_rise && !shutdown) |=> !pend);
endmodule

// File: rtl/fsd_shifter.sv
module fsd_shifter #(
   parameter int unsigned MAX_LEN = 64
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic               shift,
   input  logic [MAX_LEN-1:0] word_in,
   output logic               msb
);
   logic [MAX_LEN-1:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     sh <= '0;
      else if (load)  sh <= word_in;
      else if (shift) sh <= {sh[MAX_LEN-2:0], 1'b0};
   end

   assign msb = sh[MAX_LEN-1];
endmodule

// File: rtl/i2s_tx_shutdown_ctrl.sv
module i2s_tx_shutdown_ctrl
   import i2s_fsd_pkg::*;
#(
   parameter int unsigned MAX_LEN  = 64,
   parameter int unsigned MIN_LEN  = 8,
   parameter int unsigned LATE_WIN = 4,
   localparam int unsigned LW      = $clog2(MAX_LEN + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tx_en,
   input  logic               clk_stop_req,
   input  logic [LW-1:0]      frame_len,
   input  logic [MAX_LEN-1:0] tx_word,
   input  logic               word_rdy,
   input  logic               done_clr,
   output logic               bclk_en,
   output logic               fsync,
   output logic               sdata,
   output logic               data_vld,
   output logic               done_flag
);
   generate
      if (LATE_WIN < 1) begin : g_bad_win
         $error("LATE_WIN must be at least 1");
      end
      if (MIN_LEN <= LATE_WIN + 1) begin : g_bad_min
         $error("MIN_LEN must exceed LATE_WIN + 1");
      end
      if (MAX_LEN < MIN_LEN) begin : g_bad_max
         $error("MAX_LEN must be at least MIN_LEN");
      end
   endgenerate

   frame_kind_t kind;
   logic        vld_q;
   logic        run;
   logic        first_bit, last_bit, snap_edge, in_win;
   logic        en_commit, win_clean, pend_eff;
   logic        boundary, idle_start, go_data, go_fill, shutdown, start;
   logic        vld_next, sh_msb;

   assign run        = (kind != FK_STOP);
   assign boundary   = run && last_bit;
   assign idle_start = !run && tx_en;
   assign go_data    = idle_start || (boundary && en_commit);
   assign go_fill    = boundary && !en_commit && !pend_eff;
   assign shutdown   = boundary && !en_commit && pend_eff;
   assign start      = go_data || go_fill;
   assign vld_next   = word_rdy && (idle_start || win_clean);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         kind  <= FK_STOP;
         vld_q <= 1'b0;
      end else if (go_data) begin
         kind  <= FK_DATA;
         vld_q <= vld_next;
      end else if (go_fill) begin
         kind  <= FK_FILL;
         vld_q <= 1'b0;
      end else if (shutdown) begin
         kind  <= FK_STOP;
         vld_q <= 1'b0;
      end
   end

   fsd_frame_timer #(.MAX_LEN(MAX_LEN), .LATE_WIN(LATE_WIN), .LW(LW)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run),
      .start     (start),
      .len_in    (frame_len),
      .first_bit (first_bit),
      .last_bit  (last_bit),
      .snap_edge (snap_edge),
      .in_win    (in_win)
   );

   fsd_enable_watch u_watch (
      .clk       (clk),
      .rst_n     (rst_n),
      .tx_en     (tx_en),
      .snap_edge (snap_edge),
      .in_win    (in_win),
      .en_commit (en_commit),
      .win_clean (win_clean)
   );

   fsd_stop_ctrl u_stop (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run),
      .tx_en     (tx_en),
      .stop_req  (clk_stop_req),
      .shutdown  (shutdown),
      .done_clr  (done_clr),
      .pend_eff  (pend_eff),
      .done_flag (done_flag)
   );

   fsd_shifter #(.MAX_LEN(MAX_LEN)) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (start),
      .shift   (run),
      .word_in (go_data ? tx_word : '0),
      .msb     (sh_msb)
   );

   assign bclk_en  = run;
   assign fsync    = first_bit;
   assign data_vld = run && vld_q;
   assign sdata    = run && sh_msb;

   // R2
   fsync_needs_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fsync |-> bclk_en);
   // R4
   vld_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bclk_en && !fsync) |-> $stable(data_vld));
   // R5
   stop_at_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bclk_en) |-> $past(last_bit));
   // R10
   stop_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bclk_en) |-> done_flag);
endmodule

// File: tb/i2s_tx_shutdown_ctrl_test.sv
module i2s_tx_shutdown_ctrl_test;
   localparam int MAXL = 64;
   localparam int LWB  = 7;
   localparam int LATE = 4;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            tx_en = 1'b0, clk_stop_req = 1'b0, word_rdy = 1'b0, done_clr = 1'b0;
   logic [LWB-1:0]  frame_len = 7'd8;
   logic [MAXL-1:0] tx_word = '0;
   logic            bclk_en, fsync, sdata, data_vld, done_flag;

   int   total = 0, bad = 0;
   bit   finished = 1'b0;
   string tag = "R1";

   always #5 clk = ~clk;

   i2s_tx_shutdown_ctrl uut (
      .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .clk_stop_req(clk_stop_req),
      .frame_len(frame_len), .tx_word(tx_word), .word_rdy(word_rdy),
      .done_clr(done_clr), .bclk_en(bclk_en), .fsync(fsync), .sdata(sdata),
      .data_vld(data_vld), .done_flag(done_flag)
   );

   // reference model built from the requirements
   logic            m_run, m_vld, m_snap, m_bad, m_pend, m_flag, m_enq;
   logic [LWB-1:0]  m_cnt, m_len;
   logic [MAXL-1:0] m_sh;
   logic            t_bnd, t_idle, t_gd, t_gf, t_sd, t_pe, t_rise, t_ok;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_run = 0; m_vld = 0; m_snap = 0; m_bad = 0; m_pend = 0; m_flag = 0;
         m_enq = 0; m_cnt = 0; m_len = 7'(MAXL); m_sh = '0;
      end else begin
         t_rise = tx_en && !m_enq;
         t_pe   = m_pend || (m_run && clk_stop_req);
         t_bnd  = m_run && (m_cnt == m_len - 1);
         t_idle = !m_run && tx_en;
         t_ok   = !m_bad && tx_en;
         t_gd   = t_idle || (t_bnd && m_snap);
         t_gf   = t_bnd && !m_snap && !t_pe;
         t_sd   = t_bnd && !m_snap && t_pe;
         if (m_run && m_cnt == m_len - 7'(LATE + 1)) begin
            m_snap = tx_en; m_bad = 0;
         end else if (m_run && m_cnt >= m_len - 7'(LATE) && !tx_en) begin
            m_bad = 1;
         end
         m_enq  = tx_en;
         m_pend = (t_sd || t_rise) ? 1'b0 : t_pe;
         if (t_sd) m_flag = 1; else if (done_clr) m_flag = 0;
         if (t_gd || t_gf) begin
            m_run = 1; m_cnt = 0; m_len = frame_len;
            m_sh  = t_gd ? tx_word : '0;
            m_vld = t_gd && word_rdy && (t_idle || t_ok);
         end else if (t_sd) begin
            m_run = 0; m_vld = 0;
         end else if (m_run) begin
            m_cnt = m_cnt + 1; m_sh = {m_sh[MAXL-2:0], 1'b0};
         end
      end
   end

   task automatic chk(input string req, input string what, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
      end
   endtask

   // one cycle: sample at negedge against model, leave inputs to caller
   task automatic step();
      @(negedge clk);
      chk(tag, "bclk_en (R8)",   bclk_en,   m_run);
      chk(tag, "fsync (R2)",     fsync,     m_run && m_cnt == 0);
      chk(tag, "data_vld (R4)",  data_vld,  m_run && m_vld);
      chk(tag, "sdata (R3)",     sdata,     m_run && m_sh[MAXL-1]);
      chk(tag, "done_flag (R10)", done_flag, m_flag);
      clk_stop_req = 0; done_clr = 0;
   endtask

   task automatic steps(input int n);
      for (int i = 0; i < n; i++) step();
   endtask

   task automatic wait_fsync();
      int guard = 0;
      do begin step(); guard++; end while (!fsync && guard < 200);
   endtask

   initial begin
      #2_000_000;
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog expired actual=hung expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      #1;
      @(negedge clk); @(negedge clk);
      // R1: reset state
      chk("R1", "bclk_en", bclk_en, 0); chk("R1", "fsync", fsync, 0);
      chk("R1", "sdata", sdata, 0);     chk("R1", "data_vld", data_vld, 0);
      chk("R1", "done_flag", done_flag, 0);
      rst_n = 1;
      step();

      // R2 / R3: start from stop, MSB-first data
      tag = "R2"; frame_len = 8; word_rdy = 1;
      tx_word = 64'hA5C3_0000_0000_0000; tx_en = 1;
      step();
      tag = "R3";
      chk("R2", "fsync at start", fsync, 1);
      chk("R3", "first bit MSB", sdata, 1);
      steps(20);

      // R5 / R7: drop enable mid-frame, no stop pending -> clock-only frames
      tag = "R5"; wait_fsync(); step(); tx_en = 0;
      tag = "R7"; steps(40);
      chk("R7", "clock still running", bclk_en, 1);
      chk("R7", "no valid data", data_vld, 0);

      // R9: stop request while clock-only frames run
      tag = "R9"; clk_stop_req = 1; steps(70);
      chk("R9", "clock stopped", bclk_en, 0);
      chk("R10", "flag set", done_flag, 1);
      tag = "R10"; done_clr = 1; step(); step();
      chk("R10", "flag cleared", done_flag, 0);

      // R11: pending stop discarded by a rising enable
      tag = "R11"; tx_en = 1; steps(3); clk_stop_req = 1; steps(2);
      wait_fsync(); tx_en = 0; step(); tx_en = 1; steps(30);
      wait_fsync(); step(); tx_en = 0; steps(50);
      chk("R11", "stop discarded", bclk_en, 1);

      // R6: late disable yields one invalid frame, then shutdown (R8)
      tag = "R6"; tx_en = 1; frame_len = 8; steps(20);
      clk_stop_req = 1; step();
      wait_fsync(); steps(6); tx_en = 0;   // now in bit len-2
      wait_fsync();
      chk("R6", "extra frame runs", bclk_en, 1);
      chk("R6", "extra frame invalid", data_vld, 0);
      tag = "R8"; steps(8);
      chk("R8", "clock stopped after extra frame", bclk_en, 0);
      chk("R8", "fsync low", fsync, 0);
      done_clr = 1; step();

      // random phase
      tag = "R4";
      for (int c = 0; c < 20000; c++) begin
         if ($urandom_range(39) == 0) tx_en = ~tx_en;
         if ($urandom_range(29) == 0) clk_stop_req = 1;
         if ($urandom_range(24) == 0) done_clr = 1;
         word_rdy  = ($urandom_range(7) != 0);
         tx_word   = {$urandom, $urandom};
         if ($urandom_range(15) == 0) frame_len = 7'($urandom_range(64, 8));
         step();
      end

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule